// File: doc/BRIEF.md
# Message-Buffered DMA Burst Controller

This block sits between a word-serial data bus and a host memory bus. Incoming serial words are gathered into an internal message FIFO. Nothing is sent towards the host while the message is still arriving. When the serial side reports the end of the message and marks it good, the block raises a bus request. After the host grants the bus, the block becomes bus master and writes the whole message to consecutive memory locations in one burst. A message that is reported bad is dropped and never reaches memory.

For the outgoing direction, a start strobe with a word count makes the block request the bus. It reads that many words from memory in one burst into the same FIFO, then releases the bus and hands the words to the serial side one at a time. A watchdog limits how long the block may own the host bus. When it expires, the bus is released, the FIFO is emptied and an error flag is raised. The host data path works either 16 bits at a time or 8 bits at a time. In 8-bit mode each word takes two byte beats, and the low byte goes first.

Top module: `msg_burst_dma`

## Requirements
- R1: After reset, hb_req, hb_oe, hb_wr, hb_rd, tx_valid and dma_err are all 0.
- R2: hb_req rises only in the cycle after msg_done is sampled with msg_good=1 and at least one word is held (a word in the same cycle as msg_done counts), or after an accepted tx_start. It never rises while a message is still being collected.
- R3: msg_done with msg_good=0 empties the FIFO and raises no request. A later message contains only its own words.
- R4: While hb_req is high, hb_oe, hb_wr and hb_rd stay 0 until hb_ack is high. From the cycle after the grant, one beat happens in each cycle in which hb_ack is high.
- R5: In 16-bit mode (cfg_byte_mode=0, sampled when the request is raised), receive word k is written with hb_wr=1, hb_addr=cfg_base+2k and hb_wdata equal to the word. Words are written in arrival order.
- R6: In 8-bit mode (cfg_byte_mode=1), receive word k takes two beats. The first beat writes bits 7:0 to cfg_base+2k and the second writes bits 15:8 to cfg_base+2k+1. Bits 15:8 of hb_wdata are 0 on both beats.
- R7: hb_req falls in the cycle after the final beat of a burst. The number of write beats equals the number of words held (twice that in 8-bit mode).
- R8: The FIFO holds DEPTH words. Receive words that arrive while it is full are dropped.
- R9: Bus ownership lasts at most CLK_MHZ*OWN_US cycles, counted from the first cycle after the grant. If the burst is not finished by then, hb_req drops, the FIFO is emptied and dma_err is set. dma_err clears when the next request is raised.
- R10: tx_start with tx_len from 1 to DEPTH, taken while idle with an empty FIFO, reads tx_len words with hb_rd from consecutive addresses (two byte beats per word in 8-bit mode, low byte first, from the low 8 bits of hb_rdata). The block then presents the words in order on tx_word with tx_valid. tx_take removes one word.
- R11: While rst is high, hb_req and hb_oe are 0 in that same cycle, before any clock edge.
- R12: rx_word_valid, msg_done and tx_start have no effect while a request or transfer is in progress. A tx_start with a non-empty FIFO or with tx_len=0 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; also gates host outputs at once |
| cfg_base | input | AW | Memory base address for the next burst |
| cfg_byte_mode | input | 1 | 1 = 8-bit host data path |
| rx_word_valid | input | 1 | Serial receive word strobe |
| rx_word | input | 16 | Serial receive word |
| msg_done | input | 1 | End-of-message strobe |
| msg_good | input | 1 | Message passed validation (with msg_done) |
| tx_start | input | 1 | Start an outgoing message fetch |
| tx_len | input | LW | Words to fetch, 1..DEPTH |
| tx_valid | output | 1 | Outgoing word available |
| tx_word | output | 16 | Outgoing word |
| tx_take | input | 1 | Serial side consumes tx_word |
| hb_req | output | 1 | Host bus request |
| hb_ack | input | 1 | Host bus grant |
| hb_oe | output | 1 | Host bus outputs driven (enables external tri-state buffers) |
| hb_wr | output | 1 | Write beat |
| hb_rd | output | 1 | Read beat |
| hb_addr | output | AW | Beat address |
| hb_wdata | output | 16 | Write data |
| hb_rdata | input | 16 | Read data, sampled at the end of a read beat |
| dma_err | output | 1 | Ownership watchdog expired |

## Verification
The bench builds the block with DEPTH=32, AW=16 and the timer scaled to CLK_MHZ=1, OWN_US=80, so the ownership limit is 80 cycles. A full 32-word burst in 8-bit mode (64 beats) therefore still fits. A grant withdrawn partway through a burst reaches the abort within a few dozen cycles. The full FIFO depth stays in play, so the 33rd and 34th words show the overflow drop. The chosen bases and lengths cover both data widths in both directions, discarded messages, inputs that arrive while the block is busy, and reset asserted during an active burst.

// File: rtl/msgdma_pkg.sv
package msgdma_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_REQ,
        ST_RX_XFER,
        ST_TX_REQ,
        ST_TX_XFER,
        ST_TX_SEND
    } dma_state_e;

    function automatic logic holds_req(dma_state_e s);
        return (s == ST_RX_REQ) || (s == ST_RX_XFER) ||
               (s == ST_TX_REQ) || (s == ST_TX_XFER);
    endfunction

    function automatic logic owns_bus(dma_state_e s);
        return (s == ST_RX_XFER) || (s == ST_TX_XFER);
    endfunction

    // Select the host-side lane for one beat: whole word, or one byte in the low lane.
    function automatic word_t lane_pick(word_t w, logic byte_mode, logic hi);
        if (!byte_mode) return w;
        return hi ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    function automatic int unsigned own_limit(int unsigned mhz, int unsigned us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/msg_fifo.sv
module msg_fifo
    import msgdma_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  word_t         din,
    input  logic          pop,
    output word_t         dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    word_t          store [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |-> (!full || pop));

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> !empty);

endmodule

// File: rtl/own_watchdog.sv
module own_watchdog #(
    parameter int unsigned LIMIT = 20000,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + CNT_W'(1);
    end

    assign expire = run && (cnt == CNT_W'(LIMIT - 1));

    p_own_cap_r9: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CNT_W'(LIMIT)));

endmodule

// File: rtl/msg_burst_dma.sv
module msg_burst_dma
    import msgdma_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DEPTH   = 32,
    parameter int CLK_MHZ = 250,
    parameter int OWN_US  = 80,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic          cfg_byte_mode,
    input  logic          rx_word_valid,
    input  logic [15:0]   rx_word,
    input  logic          msg_done,
    input  logic          msg_good,
    input  logic          tx_start,
    input  logic [LW-1:0] tx_len,
    output logic          tx_valid,
    output logic [15:0]   tx_word,
    input  logic          tx_take,
    output logic          hb_req,
    input  logic          hb_ack,
    output logic          hb_oe,
    output logic          hb_wr,
    output logic          hb_rd,
    output logic [AW-1:0] hb_addr,
    output logic [15:0]   hb_wdata,
    input  logic [15:0]   hb_rdata,
    output logic          dma_err
);

    localparam int unsigned LIMIT = own_limit(CLK_MHZ, OWN_US);

    dma_state_e     st;
    logic [AW-1:0]  addr_q;
    logic           bm_q;
    logic           half_q;
    logic [7:0]     lo_q;
    logic [LW-1:0]  len_q;
    logic [LW-1:0]  wcnt_q;
    logic           err_q;

    logic           f_flush, f_push, f_pop, f_full, f_empty;
    word_t          f_din, f_dout;
    logic [LW-1:0]  f_cnt;

    logic owning, beat, word_edge, rx_last, tx_last, xfer_done, expire, abort;
    logic rx_accept, tx_accept;

    msg_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (f_flush),
        .push  (f_push),
        .din   (f_din),
        .pop   (f_pop),
        .dout  (f_dout),
        .count (f_cnt),
        .full  (f_full),
        .empty (f_empty)
    );

    own_watchdog #(.LIMIT(LIMIT)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .run    (owning),
        .expire (expire)
    );

    assign owning    = owns_bus(st);
    assign beat      = owning && hb_ack;
    assign word_edge = !bm_q || half_q;
    assign rx_last   = (f_cnt == LW'(1)) && word_edge;
    assign tx_last   = (wcnt_q == len_q - LW'(1)) && word_edge;
    assign xfer_done = beat && ((st == ST_RX_XFER) ? rx_last : tx_last);
    assign abort     = expire && !xfer_done;

    // Idle-state decisions: end of message first, then outgoing start.
    assign rx_accept = msg_good && ((f_cnt != '0) || (rx_word_valid && !f_full));
    assign tx_accept = tx_start && f_empty && (tx_len != '0) && (tx_len <= LW'(DEPTH));

    always_comb begin
        f_push  = 1'b0;
        f_pop   = 1'b0;
        f_flush = 1'b0;
        f_din   = rx_word;
        unique case (st)
            ST_IDLE: begin
                if (msg_done) begin
                    f_push  = rx_word_valid && !f_full;
                    f_flush = !rx_accept;
                end else if (!tx_accept) begin
                    f_push  = rx_word_valid && !f_full;
                end
            end
            ST_RX_XFER: begin
                f_pop   = beat && word_edge;
                f_flush = abort;
            end
            ST_TX_XFER: begin
                f_push  = beat && word_edge;
                f_din   = bm_q ? {hb_rdata[7:0], lo_q} : hb_rdata;
                f_flush = abort;
            end
            ST_TX_SEND: f_pop = tx_take && !f_empty;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            addr_q <= '0;
            bm_q   <= 1'b0;
            half_q <= 1'b0;
            lo_q   <= '0;
            len_q  <= '0;
            wcnt_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (msg_done) begin
                        if (rx_accept) begin
                            st     <= ST_RX_REQ;
                            addr_q <= cfg_base;
                            bm_q   <= cfg_byte_mode;
                            half_q <= 1'b0;
                            err_q  <= 1'b0;
                        end
                    end else if (tx_accept) begin
                        st     <= ST_TX_REQ;
                        addr_q <= cfg_base;
                        bm_q   <= cfg_byte_mode;
                        half_q <= 1'b0;
                        len_q  <= tx_len;
                        wcnt_q <= '0;
                        err_q  <= 1'b0;
                    end
                end
                ST_RX_REQ: if (hb_ack) st <= ST_RX_XFER;
                ST_TX_REQ: if (hb_ack) st <= ST_TX_XFER;
                ST_RX_XFER: begin
                    if (abort) begin
                        st    <= ST_IDLE;
                        err_q <= 1'b1;
                    end else if (beat) begin
                        addr_q <= addr_q + (bm_q ? AW'(1) : AW'(2));
                        half_q <= bm_q && !half_q;
                        if (rx_last) st <= ST_IDLE;
                    end
                end
                ST_TX_XFER: begin
                    if (abort) begin
                        st    <= ST_IDLE;
                        err_q <= 1'b1;
                    end else if (beat) begin
                        addr_q <= addr_q + (bm_q ? AW'(1) : AW'(2));
                        if (bm_q && !half_q) begin
                            lo_q   <= hb_rdata[7:0];
                            half_q <= 1'b1;
                        end else begin
                            half_q <= 1'b0;
                            wcnt_q <= wcnt_q + LW'(1);
                        end
                        if (tx_last) st <= ST_TX_SEND;
                    end
                end
                ST_TX_SEND: if (f_pop && (f_cnt == LW'(1))) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Host-side outputs are cut by rst without waiting for a clock edge.
    assign hb_req   = holds_req(st) && !rst;
    assign hb_oe    = beat && !rst;
    assign hb_wr    = hb_oe && (st == ST_RX_XFER);
    assign hb_rd    = hb_oe && (st == ST_TX_XFER);
    assign hb_addr  = hb_oe ? addr_q : '0;
    assign hb_wdata = hb_wr ? lane_pick(f_dout, bm_q, half_q) : '0;
    assign tx_valid = (st == ST_TX_SEND) && !f_empty;
    assign tx_word  = tx_valid ? f_dout : '0;
    assign dma_err  = err_q;

    p_oe_needs_grant_r4: assert property (@(posedge clk) disable iff (rst)
        hb_oe |-> (hb_req && hb_ack));

    p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(hb_wr && hb_rd));

    p_bad_msg_no_req_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && msg_done && !msg_good) |=> !hb_req);

    p_req_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(hb_req) |-> $past(msg_done || tx_start));

    p_word_step_r5: assert property (@(posedge clk) disable iff (rst)
        (hb_wr && $past(hb_wr) && !bm_q) |-> (hb_addr == $past(hb_addr) + AW'(2)));

    p_abort_release_r9: assert property (@(posedge clk) disable iff (rst)
        abort |=> (dma_err && !hb_req));

endmodule

// File: tb/test_msg_burst_dma.sv
module test_msg_burst_dma;

    localparam int AW = 16;
    localparam int D  = 32;
    localparam int LW = $clog2(D + 1);
    localparam int TMO = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] cfg_base = '0;
    logic cfg_byte_mode = 1'b0;
    logic rx_word_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic msg_done = 1'b0, msg_good = 1'b0;
    logic tx_start = 1'b0;
    logic [LW-1:0] tx_len = '0;
    logic tx_valid, tx_take = 1'b0;
    logic [15:0] tx_word;
    logic hb_req, hb_ack = 1'b0, hb_oe, hb_wr, hb_rd;
    logic [AW-1:0] hb_addr;
    logic [15:0] hb_wdata, hb_rdata;
    logic dma_err;

    always #2 clk = ~clk;

    msg_burst_dma #(.AW(AW), .DEPTH(D), .CLK_MHZ(1), .OWN_US(TMO)) i_msg_burst_dma (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_byte_mode(cfg_byte_mode),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .msg_done(msg_done),
        .msg_good(msg_good), .tx_start(tx_start), .tx_len(tx_len),
        .tx_valid(tx_valid), .tx_word(tx_word), .tx_take(tx_take),
        .hb_req(hb_req), .hb_ack(hb_ack), .hb_oe(hb_oe), .hb_wr(hb_wr), .hb_rd(hb_rd),
        .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .dma_err(dma_err)
    );

    // Host memory
    logic [15:0] mem [0:1023];
    int wr_seen = 0;
    assign hb_rdata = mem[hb_addr[9:0]];
    always @(posedge clk) if (hb_wr) begin
        mem[hb_addr[9:0]] <= hb_wdata;
        wr_seen <= wr_seen + 1;
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;                // 0 idle 1 rx-req 2 rx-xfer 3 tx-req 4 tx-xfer 5 tx-send
    logic [15:0] m_addr = '0;
    bit m_bm = 0, m_half = 0, m_err = 0;
    logic [7:0] m_lo = '0;
    int m_len = 0, m_wcnt = 0, m_tc = 0;
    logic [15:0] q[$];
    bit cmp_on = 0;

    always @(posedge clk) begin
        cmp_on <= 1;
        if (rst) begin
            m_st = 0; m_addr = '0; m_bm = 0; m_half = 0; m_err = 0; m_tc = 0; q.delete();
        end else begin
            case (m_st)
                0: begin
                    if (msg_done) begin
                        if (rx_word_valid && q.size() < D) q.push_back(rx_word);
                        if (msg_good && q.size() > 0) begin
                            m_st = 1; m_addr = cfg_base; m_bm = cfg_byte_mode; m_half = 0; m_err = 0;
                        end else q.delete();
                    end else if (tx_start && q.size() == 0 && tx_len >= 1 && tx_len <= D) begin
                        m_st = 3; m_addr = cfg_base; m_bm = cfg_byte_mode; m_half = 0;
                        m_len = int'(tx_len); m_wcnt = 0; m_err = 0;
                    end else if (rx_word_valid && q.size() < D) q.push_back(rx_word);
                end
                1, 3: if (hb_ack) begin m_st = m_st + 1; m_tc = 0; end
                2: begin
                    bit last;
                    last = hb_ack && q.size() == 1 && (!m_bm || m_half);
                    if (m_tc == TMO - 1 && !last) begin
                        q.delete(); m_err = 1; m_st = 0;
                    end else if (hb_ack) begin
                        m_addr = m_addr + (m_bm ? 16'd1 : 16'd2);
                        if (!m_bm || m_half) void'(q.pop_front());
                        m_half = m_bm && !m_half;
                        if (last) m_st = 0;
                    end
                    m_tc++;
                end
                4: begin
                    bit last;
                    logic [15:0] rd;
                    rd = mem[m_addr[9:0]];
                    last = hb_ack && m_wcnt == m_len - 1 && (!m_bm || m_half);
                    if (m_tc == TMO - 1 && !last) begin
                        q.delete(); m_err = 1; m_st = 0;
                    end else if (hb_ack) begin
                        m_addr = m_addr + (m_bm ? 16'd1 : 16'd2);
                        if (m_bm && !m_half) begin m_lo = rd[7:0]; m_half = 1; end
                        else begin
                            q.push_back(m_bm ? {rd[7:0], m_lo} : rd);
                            m_half = 0; m_wcnt++;
                        end
                        if (last) m_st = 5;
                    end
                    m_tc++;
                end
                5: if (tx_take && q.size() > 0) begin
                    void'(q.pop_front());
                    if (q.size() == 0) m_st = 0;
                end
                default: m_st = 0;
            endcase
        end
    end

    // Compare every cycle, between the input update at negedge and the next posedge
    always begin
        @(negedge clk);
        #1;
        if (cmp_on) begin
            bit e_req, e_oe, e_tv;
            e_req = (m_st >= 1 && m_st <= 4) && !rst;
            e_oe  = (m_st == 2 || m_st == 4) && hb_ack && !rst;
            e_tv  = (m_st == 5) && q.size() > 0;
            chk("R2 hb_req", int'(hb_req), int'(e_req));
            chk("R4 hb_oe", int'(hb_oe), int'(e_oe));
            chk("R5 hb_wr", int'(hb_wr), int'(e_oe && m_st == 2));
            chk("R10 hb_rd", int'(hb_rd), int'(e_oe && m_st == 4));
            chk("R9 dma_err", int'(dma_err), int'(m_err));
            chk("R10 tx_valid", int'(tx_valid), int'(e_tv));
            if (e_oe) chk("R5 hb_addr", int'(hb_addr), int'(m_addr));
            if (e_oe && m_st == 2) begin
                logic [15:0] w;
                w = q[0];
                chk("R6 hb_wdata", int'(hb_wdata),
                    int'(!m_bm ? w : (m_half ? {8'h00, w[15:8]} : {8'h00, w[7:0]})));
            end
            if (e_tv) chk("R10 tx_word", int'(tx_word), int'(q[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_msg(int n, bit good, logic [15:0] first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_word_valid = 1; rx_word = first + 16'(i);
        end
        @(negedge clk);
        rx_word_valid = 0; msg_done = 1; msg_good = good;
        @(negedge clk);
        msg_done = 0; msg_good = 0;
    endtask

    task automatic grant(int delay);
        while (!hb_req) @(negedge clk);
        repeat (delay) @(negedge clk);
        hb_ack = 1;
        while (hb_req) @(negedge clk);
        hb_ack = 0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete (R1 bench timeout)");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 hb_req after reset", int'(hb_req), 0);
        chk("R1 hb_oe after reset", int'(hb_oe), 0);
        chk("R1 hb_wr/hb_rd after reset", int'(hb_wr | hb_rd), 0);
        chk("R1 tx_valid after reset", int'(tx_valid), 0);
        chk("R1 dma_err after reset", int'(dma_err), 0);
        @(negedge clk); rst = 0;

        // 16-bit receive, grant after delay
        cfg_base = 16'h0100; cfg_byte_mode = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_word_valid = 1; rx_word = 16'h1A00 + 16'(i);
        end
        @(negedge clk); rx_word_valid = 0; #1;
        chk("R2 no request while collecting", int'(hb_req), 0);
        for (int i = 3; i < 5; i++) begin
            @(negedge clk); rx_word_valid = 1; rx_word = 16'h1A00 + 16'(i);
        end
        @(negedge clk); rx_word_valid = 0; msg_done = 1; msg_good = 1;
        @(negedge clk); msg_done = 0; msg_good = 0;
        wr_seen = 0;
        grant(3);
        #1;
        chk("R7 request dropped after last beat", int'(hb_req), 0);
        chk("R7 write beat count", wr_seen, 5);
        for (int i = 0; i < 5; i++) chk("R5 word in memory", int'(mem[10'h100 + 2*i]), 16'h1A00 + i);

        // bad message discarded, next message clean
        cfg_base = 16'h0140;
        send_msg(3, 0, 16'hBAD0);
        repeat (3) @(negedge clk); #1;
        chk("R3 no request for bad message", int'(hb_req), 0);
        send_msg(2, 1, 16'h2B00);
        grant(0);
        chk("R3 first word of clean message", int'(mem[10'h140]), 16'h2B00);
        chk("R3 second word of clean message", int'(mem[10'h142]), 16'h2B01);
        chk("R3 nothing after clean message", int'(mem[10'h144]), 0);

        // byte mode receive
        cfg_base = 16'h0180; cfg_byte_mode = 1;
        send_msg(4, 1, 16'hC3A1);
        wr_seen = 0;
        grant(1);
        chk("R6 byte beat count", wr_seen, 8);
        for (int i = 0; i < 4; i++) begin
            logic [15:0] w;
            w = 16'hC3A1 + 16'(i);
            chk("R6 low byte", int'(mem[10'h180 + 2*i]), int'(w[7:0]));
            chk("R6 high byte", int'(mem[10'h181 + 2*i]), int'(w[15:8]));
        end

        // overflow: 34 words, 32 kept
        cfg_base = 16'h0200; cfg_byte_mode = 0;
        send_msg(34, 1, 16'h4000);
        grant(0);
        chk("R8 last kept word", int'(mem[10'h23E]), 16'h401F);
        chk("R8 dropped words not written", int'(mem[10'h240]), 0);

        // watchdog abort: grant withdrawn mid-burst
        cfg_base = 16'h0300;
        send_msg(32, 1, 16'h5000);
        while (!hb_req) @(negedge clk);
        hb_ack = 1;
        repeat (10) @(negedge clk);
        hb_ack = 0;
        while (hb_req) @(negedge clk);
        #1;
        chk("R9 error flag after expiry", int'(dma_err), 1);
        chk("R9 bus released", int'(hb_req | hb_oe), 0);
        chk("R9 unsent word never written", int'(mem[10'h33E]), 0);

        // transmit, 16-bit
        for (int i = 0; i < 4; i++) mem[10'h380 + 2*i] = 16'h6E00 + 16'(i);
        @(negedge clk);
        cfg_base = 16'h0380; tx_start = 1; tx_len = LW'(4);
        @(negedge clk); tx_start = 0; #1;
        chk("R9 error cleared by new request", int'(dma_err), 0);
        grant(2);
        for (int k = 0; k < 4; ) begin
            @(negedge clk); #1;
            tx_take = 0;
            if (tx_valid) begin
                chk("R10 outgoing word", int'(tx_word), 16'h6E00 + k);
                k++;
                tx_take = 1;
                @(negedge clk); tx_take = 0;
            end
        end
        @(negedge clk); #1;
        chk("R10 outgoing queue drained", int'(tx_valid), 0);

        // transmit, byte mode
        for (int i = 0; i < 6; i++) mem[10'h3C0 + i] = 16'h0090 + 16'(i);
        cfg_base = 16'h03C0; cfg_byte_mode = 1;
        @(negedge clk); tx_start = 1; tx_len = LW'(3);
        @(negedge clk); tx_start = 0;
        grant(0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R10 byte-assembled word", int'(tx_word), ((16'h91 + 2*k) << 8) | (16'h90 + 2*k));
            tx_take = 1;
            @(negedge clk); tx_take = 0;
        end

        // inputs ignored while busy
        cfg_base = 16'h0280; cfg_byte_mode = 0;
        send_msg(2, 1, 16'h7700);
        @(negedge clk);
        rx_word_valid = 1; rx_word = 16'hEEEE; tx_start = 1; tx_len = LW'(2); msg_done = 1; msg_good = 1;
        @(negedge clk);
        rx_word_valid = 0; tx_start = 0; msg_done = 0; msg_good = 0;
        grant(0);
        chk("R12 held word 1", int'(mem[10'h282]), 16'h7701);
        chk("R12 word while busy not written", int'(mem[10'h284]), 0);
        repeat (3) @(negedge clk); #1;
        chk("R12 no extra request", int'(hb_req), 0);

        // reset during an active burst
        cfg_base = 16'h02C0;
        send_msg(8, 1, 16'h8800);
        while (!hb_req) @(negedge clk);
        hb_ack = 1;
        repeat (3) @(negedge clk);
        rst = 1; #1;
        chk("R11 hb_oe cut during reset", int'(hb_oe), 0);
        chk("R11 hb_req cut during reset", int'(hb_req), 0);
        @(negedge clk); hb_ack = 0;
        @(negedge clk); rst = 0;
        repeat (3) @(negedge clk); #1;
        chk("R1 idle after reset", int'(hb_req | dma_err | tx_valid), 0);

        finish_run();
    end

endmodule